// File: doc/BRIEF.md
# Shared-Pin DRAM Access and Refresh Controller

This controller connects a simple host request port to a 4-bit-wide dynamic memory. The memory is built from four square planes, each 2048 x 2048, so every access moves one nibble. The host gives a 22-bit word address, a direction flag and write data. The controller splits that address over a shared 11-bit address bus. It first presents the row half while the row strobe is low. It then presents the column half while the row and column strobes are both low. Write enable or output enable picks the direction. Between any two cycles the row strobe returns high for a precharge period.

The cells leak charge, so the controller also runs refresh on its own. An interval timer marks a refresh as due. The due refresh is serviced at the next idle point and never cuts an access short. A refresh drives the row strobe only, with the address taken from an internal row counter that visits every row in turn. A host request that arrives while a refresh is due waits until that refresh is finished.

Top module: `mux_dram_ctrl`

## Requirements
- R1: While reset is held and just after it is released: `rasN`, `casN`, `weN` and `oeN` are high (1 means inactive), `dramDqOe` is 0, and `reqAck`, `busy` and `rdValid` are 0.
- R2: `reqAck` is high, in the same cycle, exactly when `reqValid` is high, the controller is idle and no refresh is due. `busy` goes high on the next clock edge.
- R3: For `ROW_CYC` cycles after acceptance, `dramAddr` carries address bits [21:11], `rasN` is low and `casN` is high.
- R4: Next, for `COL_CYC` cycles, `dramAddr` carries address bits [10:0] and `rasN` and `casN` are both low. `casN` is never low while `rasN` is high.
- R5: During the column phase of a write (`reqWrite`=1), `weN` is low, `oeN` is high, `dramDqOe` is 1 and `dramDqOut` equals the accepted write data. `weN` and `oeN` are never low together.
- R6: During the column phase of a read, `oeN` is low, `weN` is high and `dramDqOe` is 0. `dramDqIn` is sampled on the last column cycle. It appears on `rdData` with a one-cycle `rdValid` pulse at the next edge, so a read returns the nibble last written to that address, or 0 if the address was never written.
- R7: `busy` stays high from the edge after acceptance until the edge that ends the column phase, the same edge on which `rdValid` rises for a read. `busy` is low throughout refresh.
- R8: After every row-strobe period, `rasN` stays high for at least `PRE_CYC` cycles before it can go low again.
- R9: Every `REF_INTERVAL` cycles a refresh becomes due. The controller services it with `rasN` low for `REF_CYC` cycles while `casN`, `weN` and `oeN` stay high.
- R10: A refresh that becomes due during an access waits until the access and its precharge are complete. While a refresh is due, `reqAck` stays low even if `reqValid` is high.
- R11: Each refresh drives the row counter value on `dramAddr`. The counter starts at 0 after reset, advances by one per refresh and wraps from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 22 | Word address, row in [21:11], column in [10:0] |
| reqWdata | input | 4 | Write nibble |
| reqAck | output | 1 | Request taken this cycle |
| busy | output | 1 | Host access in progress |
| rdValid | output | 1 | One-cycle read data strobe |
| rdData | output | 4 | Read nibble |
| dramAddr | output | 11 | Shared row/column address bus |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| dramDqOut | output | 4 | Data driven to the memory |
| dramDqOe | output | 1 | Data output enable toward the memory |
| dramDqIn | input | 4 | Data returned by the memory |

## Verification
The acknowledge appears in the same cycle as the request. The row phase starts one edge later. The column phase follows `ROW_CYC` cycles after that. `busy` falls and `rdValid` rises `ROW_CYC + COL_CYC` edges after the accepting edge. A due refresh takes the bus on the first edge at which the controller is idle. A behavioural reference model steps its own phase counters, refresh timer and shadow of written data on every rising edge. Every pin is compared against it in the middle of the low clock phase. At that point all registered outputs have settled, and the combinational acknowledge has settled against inputs that change on the falling edge.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } mdcState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic rasOn;
    logic casOn;
    logic wrOn;
    logic rdOn;
    logic selCol;
    logic selRef;
    logic load;
    logic capture;
  } mdcStrobe_t;

endpackage

// File: rtl/mdc_control.sv
module mdc_control
  import mdc_pkg::*;
#(
  parameter int ROW_BITS     = 11,
  parameter int ROW_CYC      = 2,
  parameter int COL_CYC      = 2,
  parameter int PRE_CYC      = 2,
  parameter int REF_CYC      = 3,
  parameter int REF_INTERVAL = 1562
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic                reqWrite,
  output logic                reqAck,
  output logic                busy,
  output mdcStrobe_t          strobe,
  output logic [ROW_BITS-1:0] refRow
);

  localparam int PH_A   = (ROW_CYC > COL_CYC) ? ROW_CYC : COL_CYC;
  localparam int PH_B   = (PRE_CYC > REF_CYC) ? PRE_CYC : REF_CYC;
  localparam int PH_MAX = (PH_A > PH_B) ? PH_A : PH_B;
  localparam int CNT_W  = $clog2(PH_MAX + 1);
  localparam int TMR_W  = $clog2(REF_INTERVAL);

  mdcState_t         state;
  logic [CNT_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  lastCnt;
  logic              phaseLast;
  logic [TMR_W-1:0]  refTimer;
  logic              timerHit;
  logic              refPending;
  logic              startRef;
  logic              isWrite;

  always_comb begin
    unique case (state)
      ST_ROW:  lastCnt = CNT_W'(ROW_CYC - 1);
      ST_COL:  lastCnt = CNT_W'(COL_CYC - 1);
      ST_PRE:  lastCnt = CNT_W'(PRE_CYC - 1);
      ST_REF:  lastCnt = CNT_W'(REF_CYC - 1);
      default: lastCnt = '0;
    endcase
  end

  assign phaseLast = (phaseCnt == lastCnt);
  assign timerHit  = (refTimer == TMR_W'(REF_INTERVAL - 1));
  assign startRef  = (state == ST_IDLE) && refPending;
  // refresh wins over a host request in the same idle cycle
  assign reqAck    = (state == ST_IDLE) && !refPending && reqValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phaseCnt   <= '0;
      refTimer   <= '0;
      refPending <= 1'b0;
      refRow     <= '0;
      busy       <= 1'b0;
      isWrite    <= 1'b0;
    end else begin
      refTimer   <= timerHit ? '0 : refTimer + 1'b1;
      refPending <= timerHit | (refPending & ~startRef);
      unique case (state)
        ST_IDLE: begin
          phaseCnt <= '0;
          if (startRef) begin
            state <= ST_REF;
          end else if (reqAck) begin
            state   <= ST_ROW;
            busy    <= 1'b1;
            isWrite <= reqWrite;
          end
        end
        ST_ROW: begin
          phaseCnt <= phaseLast ? '0 : phaseCnt + 1'b1;
          if (phaseLast) state <= ST_COL;
        end
        ST_COL: begin
          phaseCnt <= phaseLast ? '0 : phaseCnt + 1'b1;
          if (phaseLast) begin
            state <= ST_PRE;
            busy  <= 1'b0;
          end
        end
        ST_PRE: begin
          phaseCnt <= phaseLast ? '0 : phaseCnt + 1'b1;
          if (phaseLast) state <= ST_IDLE;
        end
        ST_REF: begin
          phaseCnt <= phaseLast ? '0 : phaseCnt + 1'b1;
          if (phaseLast) begin
            state  <= ST_PRE;
            refRow <= refRow + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.rasOn   = (state == ST_ROW) || (state == ST_COL) || (state == ST_REF);
    strobe.casOn   = (state == ST_COL);
    strobe.wrOn    = (state == ST_COL) && isWrite;
    strobe.rdOn    = (state == ST_COL) && !isWrite;
    strobe.selCol  = (state == ST_COL);
    strobe.selRef  = (state == ST_REF);
    strobe.load    = reqAck;
    strobe.capture = (state == ST_COL) && phaseLast && !isWrite;
  end

  p_busy_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqAck |=> busy);

  p_idle_during_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REF) |-> !busy);

  p_pending_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && refPending) |=> (state == ST_REF));

  p_row_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_REF && state == ST_PRE) |-> (refRow == $past(refRow) + 1'b1));

endmodule

// File: rtl/mdc_datapath.sv
module mdc_datapath
  import mdc_pkg::*;
#(
  parameter int ROW_BITS = 11,
  parameter int COL_BITS = 11,
  parameter int DATA_W   = 4,
  parameter int PRE_CYC  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  mdcStrobe_t                   strobe,
  input  logic [ROW_BITS+COL_BITS-1:0] reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  input  logic [ROW_BITS-1:0]          refRow,
  input  logic [DATA_W-1:0]            dramDqIn,
  output logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] dramAddr,
  output logic                         rasN,
  output logic                         casN,
  output logic                         weN,
  output logic                         oeN,
  output logic [DATA_W-1:0]            dramDqOut,
  output logic                         dramDqOe,
  output logic [DATA_W-1:0]            rdData,
  output logic                         rdValid
);

  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int PIN_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
  localparam int RUN_W  = $clog2(PRE_CYC + 1);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ   <= '0;
      dataQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
      end
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= dramDqIn;
    end
  end

  always_comb begin
    if (strobe.selRef)      dramAddr = PIN_W'(refRow);
    else if (strobe.selCol) dramAddr = PIN_W'(addrQ[COL_BITS-1:0]);
    else                    dramAddr = PIN_W'(addrQ[ADDR_W-1 -: ROW_BITS]);
  end

  assign rasN      = ~strobe.rasOn;
  assign casN      = ~strobe.casOn;
  assign weN       = ~strobe.wrOn;
  assign oeN       = ~strobe.rdOn;
  assign dramDqOe  = strobe.wrOn;
  assign dramDqOut = dataQ;

  // length of the current row-strobe-high run, saturating
  logic [RUN_W-1:0] highRun;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      highRun <= RUN_W'(PRE_CYC);
    end else if (rasN) begin
      if (int'(highRun) < PRE_CYC) highRun <= highRun + 1'b1;
    end else begin
      highRun <= '0;
    end
  end

  p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !casN |-> !rasN);

  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!weN && !oeN));

  p_rdvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> !rdValid);

  p_precharge_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) |-> (int'(highRun) + 1 >= PRE_CYC));

endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mdc_pkg::*;
#(
  parameter int ROW_BITS     = 11,
  parameter int COL_BITS     = 11,
  parameter int DATA_W       = 4,
  parameter int ROW_CYC      = 2,
  parameter int COL_CYC      = 2,
  parameter int PRE_CYC      = 2,
  parameter int REF_CYC      = 3,
  parameter int REF_INTERVAL = 1562
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic [ROW_BITS+COL_BITS-1:0] reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  output logic                         reqAck,
  output logic                         busy,
  output logic                         rdValid,
  output logic [DATA_W-1:0]            rdData,
  output logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] dramAddr,
  output logic                         rasN,
  output logic                         casN,
  output logic                         weN,
  output logic                         oeN,
  output logic [DATA_W-1:0]            dramDqOut,
  output logic                         dramDqOe,
  input  logic [DATA_W-1:0]            dramDqIn
);

  mdcStrobe_t          strobe;
  logic [ROW_BITS-1:0] refRow;

  mdc_control #(
    .ROW_BITS(ROW_BITS), .ROW_CYC(ROW_CYC), .COL_CYC(COL_CYC),
    .PRE_CYC(PRE_CYC), .REF_CYC(REF_CYC), .REF_INTERVAL(REF_INTERVAL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAck(reqAck), .busy(busy), .strobe(strobe), .refRow(refRow)
  );

  mdc_datapath #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W), .PRE_CYC(PRE_CYC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .refRow(refRow), .dramDqIn(dramDqIn),
    .dramAddr(dramAddr), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/tb_mux_dram_ctrl.sv
module tb_mux_dram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ROWC = 2;
  localparam int COLC = 2;
  localparam int PREC = 2;
  localparam int REFC = 3;
  localparam int REFI = 40;
  localparam int NROWS = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;
  logic        reqAck, busy, rdValid;
  logic [3:0]  rdData;
  logic [10:0] dramAddr;
  logic        rasN, casN, weN, oeN;
  logic [3:0]  dramDqOut;
  logic        dramDqOe;
  logic [3:0]  dramDqIn = '0;

  int checks = 0;
  int failures = 0;

  mux_dram_ctrl #(
    .ROW_CYC(ROWC), .COL_CYC(COLC), .PRE_CYC(PREC),
    .REF_CYC(REFC), .REF_INTERVAL(REFI)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .busy(busy),
    .rdValid(rdValid), .rdData(rdData), .dramAddr(dramAddr), .rasN(rasN),
    .casN(casN), .weN(weN), .oeN(oeN), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural memory on the pins
  logic [3:0]  memArr [logic [21:0]];
  logic [10:0] rowLat = '0;
  always @(posedge clk) begin
    if (!rasN && casN) rowLat <= dramAddr;
    if (!casN && !weN) memArr[{rowLat, dramAddr}] = dramDqOut;
  end
  always @(negedge clk) begin
    if (memArr.exists({rowLat, dramAddr})) dramDqIn <= memArr[{rowLat, dramAddr}];
    else dramDqIn <= 4'h0;
  end

  // reference model: 0 idle, 1 row, 2 column, 3 precharge, 4 refresh
  int  mMode, mCnt, mTimer, mRow, mRefs;
  bit  mPend, mWr, mBusy, mRdValid, sawWrap;
  logic [21:0] mAddr;
  logic [3:0]  mData, mRdData;
  logic [3:0]  shadow [logic [21:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      mMode = 0; mCnt = 0; mTimer = 0; mRow = 0; mPend = 0;
      mWr = 0; mBusy = 0; mRdValid = 0; mAddr = '0; mData = '0;
    end else begin
      mRdValid = 0;
      case (mMode)
        0: if (mPend) begin
             mMode = 4; mCnt = 0; mPend = 0;
           end else if (reqValid) begin
             mMode = 1; mCnt = 0; mBusy = 1; mWr = reqWrite;
             mAddr = reqAddr; mData = reqWdata;
             if (reqWrite) shadow[reqAddr] = reqWdata;
           end
        1: if (mCnt == ROWC-1) begin mMode = 2; mCnt = 0; end else mCnt++;
        2: if (mCnt == COLC-1) begin
             mMode = 3; mCnt = 0; mBusy = 0;
             if (!mWr) begin
               mRdValid = 1;
               mRdData = shadow.exists(mAddr) ? shadow[mAddr] : 4'h0;
             end
           end else mCnt++;
        3: if (mCnt == PREC-1) begin mMode = 0; mCnt = 0; end else mCnt++;
        default: if (mCnt == REFC-1) begin
             mMode = 3; mCnt = 0; mRefs++;
             if (mRow == NROWS-1) sawWrap = 1;
             mRow = (mRow + 1) % NROWS;
           end else mCnt++;
      endcase
      if (mTimer == REFI-1) begin mTimer = 0; mPend = 1; end else mTimer++;
    end
  end

  // per-cycle comparison in the middle of the low phase
  int rasHigh = 100;
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      bit expAck, expRas, expCas, expWe, expOe, expOe2;
      expAck = (mMode == 0) && !mPend && reqValid;
      expRas = !(mMode == 1 || mMode == 2 || mMode == 4);
      expCas = !(mMode == 2);
      expWe  = !(mMode == 2 && mWr);
      expOe  = !(mMode == 2 && !mWr);
      expOe2 = (mMode == 2 && mWr);
      chk(reqAck == expAck, mPend ? "R10" : "R2", "reqAck", reqAck, expAck);
      chk(busy == mBusy, "R7", "busy", busy, mBusy);
      chk(rasN == expRas, (mMode == 4) ? "R9" : "R3", "rasN", rasN, expRas);
      chk(casN == expCas, (mMode == 4) ? "R9" : "R4", "casN", casN, expCas);
      chk(weN == expWe, "R5", "weN", weN, expWe);
      chk(oeN == expOe, "R6", "oeN", oeN, expOe);
      chk(dramDqOe == expOe2, "R5", "dramDqOe", dramDqOe, expOe2);
      if (expOe2) chk(dramDqOut == mData, "R5", "dramDqOut", dramDqOut, mData);
      if (mMode == 1) chk(dramAddr == mAddr[21:11], "R3", "row addr", dramAddr, mAddr[21:11]);
      if (mMode == 2) chk(dramAddr == mAddr[10:0], "R4", "col addr", dramAddr, mAddr[10:0]);
      if (mMode == 4) chk(dramAddr == 11'(mRow), "R11", "refresh row", dramAddr, mRow);
      chk(rdValid == mRdValid, "R6", "rdValid", rdValid, mRdValid);
      if (mRdValid) chk(rdData == mRdData, "R6", "rdData", rdData, mRdData);
      // R8: measured run of row-strobe-high cycles
      if (rasN) rasHigh++;
      else begin
        if (rasHigh > 0) chk(rasHigh >= PREC, "R8", "precharge run", rasHigh, PREC);
        rasHigh = 0;
      end
    end
  end

  task automatic hostOp(input bit wr, input logic [21:0] a, input logic [3:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    forever begin
      #1;
      if (reqAck) break;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 while reset held
    chk(rasN && casN && weN && oeN, "R1", "strobes in reset", {rasN, casN, weN, oeN}, 4'hF);
    chk(!reqAck && !busy && !rdValid && !dramDqOe, "R1", "outputs in reset",
        {reqAck, busy, rdValid, dramDqOe}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(rasN && casN && !busy, "R1", "after reset", {rasN, casN, busy}, 3'b110);

    // directed corners
    hostOp(1, 22'h000000, 4'hA);
    hostOp(1, 22'h3FFFFF, 4'h5);
    hostOp(1, 22'h155AAA, 4'hC);
    hostOp(1, 22'h2AA555, 4'h3);
    hostOp(0, 22'h3FFFFF, 4'h0);
    hostOp(0, 22'h000000, 4'h0);
    hostOp(0, 22'h2AA555, 4'h0);
    hostOp(0, 22'h155AAA, 4'h0);
    hostOp(0, 22'h123456, 4'h0);   // never written: reads 0

    // back-to-back mixed traffic, so refresh lands inside accesses (R10)
    for (int i = 0; i < 400; i++) begin
      logic [21:0] a;
      a = {$urandom} % 16;
      a = {a[3:2], 9'h0, a[1:0], 9'h1F};
      hostOp($urandom % 2, a, 4'($urandom));
    end

    // idle long enough for the row counter to wrap (R11)
    repeat ((NROWS + 8) * REFI) @(negedge clk);
    chk(sawWrap, "R11", "row counter wrap observed", sawWrap, 1);
    chk(mRefs > NROWS, "R9", "refresh count", mRefs, NROWS + 1);

    hostOp(1, 22'h0007FF, 4'h9);
    hostOp(0, 22'h0007FF, 4'h0);
    repeat (10) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule